// File: doc/BRIEF.md
# Stop-Grant Sleep Entry Sequencer

This block steps a system controller into and out of its low-power sleep state. A decoded stop-grant special cycle from the host bus starts it. When the stop-grant disconnect enable is set, the block does three things in turn. It waits until every internal request queue reports empty. It then asks the memory controller to put DDR memory into self-refresh, but only if the configuration allows self-refresh. It then hands the stop-grant cycle to the downstream PCI side. After that, while the active-low clock-stop input is held low, the block gates the internal clock trees.

When clock-stop is released, the block first restores the clocks. It then asks the memory controller to take memory out of self-refresh, and it returns to idle when that request is acknowledged. The DRAM clock outputs follow the internal clock gate, except in registered-DIMM mode, where they keep running through the whole sleep. The block never touches the PLLs, so no relock wait is needed on resume.

A busy output tells the host interface to refuse inbound traffic while a sequence is in progress. Two sticky error flags report problems: one for a skipped self-refresh step and one for a drain timeout.

Top module: `sleep_seq`

## Requirements
- R1: With `cfg_discon_en` low, a stop-grant pulse is forwarded only. The block goes straight to FORWARD, never requests self-refresh and returns to IDLE on `fwd_ack`. It does not gate clocks even if `clk_stop_n` is then driven low.
- R2: With `cfg_discon_en` high, the order is fixed. The block stays in DRAIN until all `q_empty` bits are 1. Only then is `sr_enter_req` raised, and only after its acknowledge is `fwd_req` raised.
- R3: Self-refresh entry is requested only when bit 19 of `dram_mode_reg` is 0 and bit 18 of `ctl_stat_reg` is 1. Otherwise the block sets the sticky `err_sr` flag, skips the self-refresh step and still forwards.
- R4: After forwarding, the block waits in WAIT_STOP with clocks on. From the cycle after `clk_stop_n` is seen low, `core_clk_en` is 0 until `clk_stop_n` is seen high again.
- R5: While the core clocks are gated, `dram_clk_en` equals `cfg_reg_dimm`. At all other times it is 1.
- R6: If the queues are still not all empty after `drain_limit`+1 cycles in DRAIN, the sticky `err_drain` flag is set. Draining then continues. The flag clears only on reset.
- R7: Each handshake request (`sr_enter_req`, `sr_exit_req`, `fwd_req`) is held and the state does not advance until the matching acknowledge arrives.
- R8: On resume, the block spends one UNGATE cycle with clocks on and no request. If self-refresh was entered, it then raises `sr_exit_req` and returns to IDLE on `sr_ack`. If self-refresh was skipped, it goes straight to IDLE.
- R9: `busy` is 1 from the cycle after the stop-grant decode until the return to IDLE. Stop-grant pulses while busy have no effect on the state.
- R10: `dbg_state` encodes IDLE=0, DRAIN=1, SR_ENTER=2, FORWARD=3, WAIT_STOP=4, GATED=5, UNGATE=6, SR_EXIT=7.
- R11: After reset the block is in IDLE. Clocks are enabled, no request is active, `busy` is 0 and both error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running, ungated controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sg_cycle | input | 1 | One-cycle pulse: stop-grant special cycle decoded |
| cfg_discon_en | input | 1 | Enable for the full drain and sleep sequence |
| cfg_reg_dimm | input | 1 | Registered DIMMs fitted; keep DRAM clocks running |
| dram_mode_reg | input | 32 | Memory mode register; bit 19 disables refresh |
| ctl_stat_reg | input | 32 | Control register; bit 18 enables self-refresh |
| q_empty | input | NQ | One empty flag per internal request queue |
| drain_limit | input | CW | Drain timeout limit in cycles |
| sr_ack | input | 1 | Memory controller acknowledge for self-refresh entry or exit |
| sr_enter_req | output | 1 | Self-refresh entry request |
| sr_exit_req | output | 1 | Self-refresh exit request |
| fwd_ack | input | 1 | PCI side has taken the stop-grant cycle |
| fwd_req | output | 1 | Forward the stop-grant cycle downstream |
| clk_stop_n | input | 1 | Active-low clock-stop from the downstream bridge |
| core_clk_en | output | 1 | Internal clock tree enable |
| dram_clk_en | output | 1 | DRAM clock output enable |
| busy | output | 1 | Sequence in progress; refuse inbound traffic |
| err_sr | output | 1 | Sticky: self-refresh was not allowed and was skipped |
| err_drain | output | 1 | Sticky: drain exceeded the limit |
| dbg_state | output | 3 | Current state code |

## Verification
The bench builds the block with three queues and an 8-bit timeout counter. A drain limit of 4 then makes the timeout fire after only a few stalled cycles, and setting the limit to 200 keeps it well out of the way in the other scenarios. The acknowledge responder waits three cycles, so every handshake state has to hold for several cycles, and those held states are observed. With registered-DIMM mode both on and off, and with self-refresh both allowed and forbidden, both resume paths and both DRAM clock behaviours are exercised.

// File: rtl/sleep_seq.sv
module sleep_seq #(
  parameter int NQ = 4,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sg_cycle,
  input  logic          cfg_discon_en,
  input  logic          cfg_reg_dimm,
  input  logic [31:0]   dram_mode_reg,
  input  logic [31:0]   ctl_stat_reg,
  input  logic [NQ-1:0] q_empty,
  input  logic [CW-1:0] drain_limit,
  input  logic          sr_ack,
  output logic          sr_enter_req,
  output logic          sr_exit_req,
  input  logic          fwd_ack,
  output logic          fwd_req,
  input  logic          clk_stop_n,
  output logic          core_clk_en,
  output logic          dram_clk_en,
  output logic          busy,
  output logic          err_sr,
  output logic          err_drain,
  output logic [2:0]    dbg_state
);
  localparam int REFDIS_BIT = 19;
  localparam int SREN_BIT   = 18;

  typedef enum logic [2:0] {
    S_IDLE, S_DRAIN, S_SR_ENTER, S_FORWARD, S_WAIT_STOP, S_GATED, S_UNGATE, S_SR_EXIT
  } st_t;

  st_t           st;
  logic          full;
  logic          sr_on;
  logic [CW-1:0] cnt;
  wire           sr_ok = !dram_mode_reg[REFDIS_BIT] && ctl_stat_reg[SREN_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      full      <= 1'b0;
      sr_on     <= 1'b0;
      cnt       <= '0;
      err_sr    <= 1'b0;
      err_drain <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (sg_cycle) begin
          full  <= cfg_discon_en;
          sr_on <= 1'b0;
          cnt   <= '0;
          st    <= cfg_discon_en ? S_DRAIN : S_FORWARD;
        end
        S_DRAIN: begin
          if (&q_empty) begin
            if (sr_ok) st <= S_SR_ENTER;
            else begin
              err_sr <= 1'b1;
              st     <= S_FORWARD;
            end
          end else if (cnt == drain_limit) err_drain <= 1'b1;
          else cnt <= cnt + 1'b1;
        end
        S_SR_ENTER: if (sr_ack) begin
          sr_on <= 1'b1;
          st    <= S_FORWARD;
        end
        S_FORWARD:   if (fwd_ack) st <= full ? S_WAIT_STOP : S_IDLE;
        S_WAIT_STOP: if (!clk_stop_n) st <= S_GATED;
        S_GATED:     if (clk_stop_n) st <= S_UNGATE;
        S_UNGATE:    st <= sr_on ? S_SR_EXIT : S_IDLE;
        S_SR_EXIT: if (sr_ack) begin
          sr_on <= 1'b0;
          st    <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign sr_enter_req = (st == S_SR_ENTER);
  assign sr_exit_req  = (st == S_SR_EXIT);
  assign fwd_req      = (st == S_FORWARD);
  assign core_clk_en  = (st != S_GATED);
  assign dram_clk_en  = core_clk_en || cfg_reg_dimm;
  assign busy         = (st != S_IDLE);
  assign dbg_state    = st;
endmodule

module sleep_seq_chk #(
  parameter int NQ = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [31:0]   dram_mode_reg,
  input logic [31:0]   ctl_stat_reg,
  input logic [NQ-1:0] q_empty,
  input logic          sr_ack,
  input logic          sr_enter_req,
  input logic          sr_exit_req,
  input logic          fwd_ack,
  input logic          fwd_req,
  input logic          clk_stop_n,
  input logic          core_clk_en,
  input logic          dram_clk_en,
  input logic          cfg_reg_dimm,
  input logic          err_sr,
  input logic          err_drain
);
  assert_sr_after_drain_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_enter_req) |-> $past(&q_empty));
  assert_sr_cfg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_enter_req) |-> !$past(dram_mode_reg[19]) && $past(ctl_stat_reg[18]));
  assert_gate_follows_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !core_clk_en |-> $past(!clk_stop_n));
  assert_dram_clk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_clk_en && cfg_reg_dimm) |-> dram_clk_en);
  assert_drain_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_drain |=> err_drain);
  assert_sr_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err_sr |=> err_sr);
  assert_fwd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_req && !fwd_ack) |=> fwd_req);
  assert_sr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_enter_req && !sr_ack) |=> sr_enter_req);
  assert_exit_clk_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sr_exit_req |-> core_clk_en && clk_stop_n);
  assert_one_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sr_enter_req, sr_exit_req, fwd_req}));
endmodule

bind sleep_seq sleep_seq_chk #(.NQ(NQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .dram_mode_reg(dram_mode_reg), .ctl_stat_reg(ctl_stat_reg),
  .q_empty(q_empty), .sr_ack(sr_ack), .sr_enter_req(sr_enter_req), .sr_exit_req(sr_exit_req),
  .fwd_ack(fwd_ack), .fwd_req(fwd_req), .clk_stop_n(clk_stop_n), .core_clk_en(core_clk_en),
  .dram_clk_en(dram_clk_en), .cfg_reg_dimm(cfg_reg_dimm), .err_sr(err_sr), .err_drain(err_drain)
);

// File: tb/sim_sleep_seq.sv
module sim_sleep_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NQ = 3;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sg_cycle = 1'b0, cfg_discon_en = 1'b0, cfg_reg_dimm = 1'b0;
  logic [31:0] dram_mode_reg = '0, ctl_stat_reg = 32'h0004_0000;
  logic [NQ-1:0] q_empty = '1;
  logic [CW-1:0] drain_limit = 8'd200;
  logic sr_ack, fwd_ack, clk_stop_n = 1'b1;
  logic sr_enter_req, sr_exit_req, fwd_req, core_clk_en, dram_clk_en, busy, err_sr, err_drain;
  logic [2:0] dbg_state;

  int n_chk = 0, n_fail = 0, cyc = 0, t_sr = -1, t_fwd = -1, t_ex = -1;
  int ack_dly = 3, sc = 0, fc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sleep_seq #(.NQ(NQ), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .sg_cycle(sg_cycle), .cfg_discon_en(cfg_discon_en),
    .cfg_reg_dimm(cfg_reg_dimm), .dram_mode_reg(dram_mode_reg), .ctl_stat_reg(ctl_stat_reg),
    .q_empty(q_empty), .drain_limit(drain_limit), .sr_ack(sr_ack), .sr_enter_req(sr_enter_req),
    .sr_exit_req(sr_exit_req), .fwd_ack(fwd_ack), .fwd_req(fwd_req), .clk_stop_n(clk_stop_n),
    .core_clk_en(core_clk_en), .dram_clk_en(dram_clk_en), .busy(busy), .err_sr(err_sr),
    .err_drain(err_drain), .dbg_state(dbg_state)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      sr_ack <= 1'b0; fwd_ack <= 1'b0; sc <= 0; fc <= 0;
    end else begin
      if ((sr_enter_req || sr_exit_req) && !sr_ack) begin
        if (sc >= ack_dly) begin sr_ack <= 1'b1; sc <= 0; end else sc <= sc + 1;
      end else sr_ack <= 1'b0;
      if (fwd_req && !fwd_ack) begin
        if (fc >= ack_dly) begin fwd_ack <= 1'b1; fc <= 0; end else fc <= fc + 1;
      end else fwd_ack <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (sr_enter_req && t_sr < 0) t_sr = cyc;
    if (fwd_req && t_fwd < 0) t_fwd = cyc;
    if (sr_exit_req && t_ex < 0) t_ex = cyc;
  endtask

  task automatic wait_state(input int s, input string tag);
    int n = 0;
    while (dbg_state != s && n < 100) begin tick(); n++; end
    check(dbg_state == s, tag, dbg_state, s);
  endtask

  task automatic start_sg();
    t_sr = -1; t_fwd = -1; t_ex = -1;
    sg_cycle = 1'b1;
    tick();
    sg_cycle = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    check(dbg_state == 0, "R11 state", dbg_state, 0);
    check(core_clk_en && dram_clk_en, "R11 clocks", {core_clk_en, dram_clk_en}, 3);
    check({sr_enter_req, sr_exit_req, fwd_req, busy} == 0, "R11 reqs",
          {sr_enter_req, sr_exit_req, fwd_req, busy}, 0);
    check({err_sr, err_drain} == 0, "R11 errors", {err_sr, err_drain}, 0);
  endtask

  task automatic t_forward_only();
    cfg_discon_en = 1'b0;
    start_sg();
    check(dbg_state == 3, "R1 straight to FORWARD", dbg_state, 3);
    check(busy, "R9 busy after decode", busy, 1);
    wait_state(0, "R1 back to IDLE");
    check(t_sr < 0, "R1 no self-refresh", t_sr, -1);
    clk_stop_n = 1'b0;
    tick(); tick();
    check(core_clk_en && dbg_state == 0, "R1 no gating", core_clk_en, 1);
    clk_stop_n = 1'b1;
    tick();
  endtask

  task automatic t_full(input bit regd);
    int ts;
    cfg_discon_en = 1'b1; cfg_reg_dimm = regd; drain_limit = 8'd200;
    q_empty = 3'b101;
    start_sg();
    check(dbg_state == 1, "R10 DRAIN code", dbg_state, 1);
    tick(); tick(); tick();
    check(dbg_state == 1 && !sr_enter_req, "R2 waits for empty queues", dbg_state, 1);
    ts = cyc;
    q_empty = 3'b111;
    tick();
    check(dbg_state == 2 && sr_enter_req, "R2 SR_ENTER after drain", dbg_state, 2);
    tick();
    check(dbg_state == 2, "R7 holds until sr_ack", dbg_state, 2);
    wait_state(3, "R2 FORWARD after SR");
    check(t_sr > ts && t_fwd > t_sr, "R2 order", t_fwd - t_sr, 1);
    tick();
    check(fwd_req, "R7 fwd_req held", fwd_req, 1);
    wait_state(4, "R4 WAIT_STOP");
    check(core_clk_en, "R4 clocks on before stop", core_clk_en, 1);
    sg_cycle = 1'b1; tick(); sg_cycle = 1'b0; tick();
    check(dbg_state == 4, "R9 pulse while busy ignored", dbg_state, 4);
    clk_stop_n = 1'b0;
    tick();
    check(dbg_state == 5 && !core_clk_en, "R4 gated", core_clk_en, 0);
    check(dram_clk_en == regd, "R5 dram clock", dram_clk_en, regd);
    tick(); tick(); tick();
    check(!core_clk_en && dram_clk_en == regd, "R4 R5 stay gated", core_clk_en, 0);
    clk_stop_n = 1'b1;
    tick();
    check(dbg_state == 6 && core_clk_en && !sr_exit_req, "R8 UNGATE first", dbg_state, 6);
    check(dram_clk_en, "R5 dram clock back", dram_clk_en, 1);
    tick();
    check(dbg_state == 7 && sr_exit_req && core_clk_en, "R8 SR_EXIT", dbg_state, 7);
    check(busy, "R9 busy in SR_EXIT", busy, 1);
    wait_state(0, "R8 IDLE after exit ack");
    check(!busy && !err_sr && !err_drain, "R9 busy drops", busy, 0);
  endtask

  task automatic t_sr_blocked();
    cfg_discon_en = 1'b1; cfg_reg_dimm = 1'b0;
    dram_mode_reg = 32'h0008_0000;
    q_empty = 3'b111;
    start_sg();
    check(dbg_state == 1, "R3 DRAIN", dbg_state, 1);
    tick();
    check(dbg_state == 3 && err_sr, "R3 skip SR and flag", dbg_state, 3);
    wait_state(4, "R3 still forwards");
    clk_stop_n = 1'b0; tick(); tick();
    clk_stop_n = 1'b1; tick();
    check(dbg_state == 6, "R8 UNGATE", dbg_state, 6);
    tick();
    check(dbg_state == 0, "R8 no exit when SR skipped", dbg_state, 0);
    check(t_sr < 0 && t_ex < 0, "R3 no SR handshakes", t_sr, -1);
    dram_mode_reg = '0;
    ctl_stat_reg = '0;
    start_sg();
    tick();
    check(dbg_state == 3 && t_sr < 0, "R3 bit18 clear blocks SR", dbg_state, 3);
    wait_state(4, "R3 WAIT_STOP");
    clk_stop_n = 1'b0; tick(); clk_stop_n = 1'b1; tick(); tick();
    check(dbg_state == 0 && err_sr, "R3 err_sr sticky", err_sr, 1);
    ctl_stat_reg = 32'h0004_0000;
  endtask

  task automatic t_timeout();
    cfg_discon_en = 1'b1; drain_limit = 8'd4;
    q_empty = 3'b011;
    start_sg();
    tick(); tick();
    check(!err_drain, "R6 no timeout yet", err_drain, 0);
    repeat (8) tick();
    check(err_drain && dbg_state == 1, "R6 timeout flagged, still draining", err_drain, 1);
    q_empty = 3'b111;
    tick();
    check(dbg_state == 2, "R6 continues after timeout", dbg_state, 2);
    wait_state(4, "R6 WAIT_STOP");
    clk_stop_n = 1'b0; tick(); clk_stop_n = 1'b1;
    wait_state(0, "R6 IDLE");
    check(err_drain, "R6 sticky", err_drain, 1);
  endtask

  initial begin
    t_reset();
    t_forward_only();
    t_full(1'b0);
    t_full(1'b1);
    t_sr_blocked();
    t_reset();
    t_timeout();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule